// File: doc/BRIEF.md
# Recirculating Serial Delay Line

This block is a fixed-length serial delay of 64 bit cells. Each rising clock edge moves every stored bit one cell onward. A one-bit source selector picks the bit that enters the first cell. When the selector is low, that bit comes from the external data pin. When it is high, it comes from a separate loop pin, which is normally tied back to the block's own output so that a stored word circulates without loss.

The block has three outputs. The last cell drives the main serial output and its complement. An extra half cell latches the last-cell value on the falling edge after each shift. This gives a copy of the output that lags it by half a clock period, which suits a downstream stage clocked by slow edges. A forwarded copy of the clock lets a following delay line be clocked from this one.

Storage is fully static, so nothing is lost while the clock is stopped in either state. An active-low asynchronous reset clears every cell and the half cell; its release is synchronised to the clock. This reset is provided only to give verification a known state.

Top module: `serial_delay_line`

## Requirements
- R1: A bit entering the first cell on a rising edge appears on `q_o` after exactly 64 rising edges, counting the edge that captured it.
- R2: With `recirc_i` = 0, the first cell loads `data_i` on each rising edge, and the value of `loop_i` has no effect on any output.
- R3: With `recirc_i` = 1, the first cell loads `loop_i` on each rising edge, and the value of `data_i` has no effect on any output.
- R4: With `recirc_i` = 1 and `loop_i` tied to `q_o`, a 64-bit word loaded in data mode repeats unchanged on `q_o` with a period of 64 rising edges.
- R5: `qn_o` is always the inverse of `q_o`.
- R6: `q_half_o` takes the last-cell value on the falling edge after each rising edge. It does not change on rising edges, so just after a rising edge it still shows the previous value of `q_o`.
- R7: While the clock is held steady, either high or low, no output changes, whatever the data, loop and select inputs do.
- R8: `clk_fwd_o` equals `clk_i` at all times.
- R9: When `rst_ni` is low, all cells and the half cell clear at once: `q_o` = 0, `qn_o` = 1 and `q_half_o` = 0. Shifting resumes on the third rising edge after release, because the release passes two synchronising flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shift clock; cells advance on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low clear, released through a synchroniser |
| recirc_i | input | 1 | Source select: 0 takes `data_i`, 1 takes `loop_i` |
| data_i | input | 1 | External serial data input |
| loop_i | input | 1 | Recirculation input, normally wired from `q_o` |
| q_o | output | 1 | Last-cell serial output |
| qn_o | output | 1 | Inverse of `q_o` |
| q_half_o | output | 1 | Last-cell value latched on the falling edge |
| clk_fwd_o | output | 1 | Forwarded clock for cascading |

## Verification
The bench measures the latency of a lone pulse against a zero background. A line one cell short or one cell long would put the pulse on the wrong edge. Noise is driven on whichever input is not selected, in both modes, so a selector that leaks the unselected source corrupts the expected stream. Recirculation is run for two full periods, so a word that slips or inverts by a single position does not match. The half-cell output is sampled just after each rising edge and just after each falling edge, and the clock is frozen high and then low: a half cell clocked on the wrong edge, or cells that move without an edge, show up at once.

// File: rtl/sdl_pkg.sv
`timescale 1ns/1ps
package sdl_pkg;

  // Source selector encoding: low takes the external pin, high takes the loop pin.
  typedef enum logic {
    SRC_EXTERNAL = 1'b0,
    SRC_LOOPBACK = 1'b1
  } src_sel_e;

  localparam int unsigned DEFAULT_CELLS     = 64;
  localparam int unsigned DEFAULT_SYNC_FLOPS = 2;

endpackage

// File: rtl/sdl_rst_sync.sv
`timescale 1ns/1ps
module sdl_rst_sync #(
  parameter int unsigned FLOPS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [FLOPS-1:0] sync_q;
  logic [FLOPS-1:0] sync_d;

  generate
    if (FLOPS == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[FLOPS-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[FLOPS-1];

endmodule

// File: rtl/sdl_src_mux.sv
`timescale 1ns/1ps
module sdl_src_mux
  import sdl_pkg::*;
(
  input  logic sel_i,
  input  logic ext_i,
  input  logic loop_i,
  output logic bit_o
);

  src_sel_e sel;

  always_comb begin
    sel = src_sel_e'(sel_i);
    unique case (sel)
      SRC_EXTERNAL: bit_o = ext_i;
      SRC_LOOPBACK: bit_o = loop_i;
      default:      bit_o = ext_i;
    endcase
  end

endmodule

// File: rtl/sdl_shift_chain.sv
`timescale 1ns/1ps
module sdl_shift_chain #(
  parameter int unsigned CELLS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic first_o,
  output logic last_o
);

  localparam int unsigned LAST = CELLS - 1;

  logic [LAST:0] cell_q;
  logic [LAST:0] cell_d;
  logic          shift_en;

  // Every cell shifts on every edge; the enable is kept explicit.
  assign shift_en = 1'b1;

  always_comb begin
    cell_d = cell_q;
    if (shift_en) begin
      cell_d[0] = bit_i;
      for (int i = 1; i <= LAST; i++) begin
        cell_d[i] = cell_q[i-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_q <= '0;
    end else begin
      cell_q <= cell_d;
    end
  end

  assign first_o = cell_q[0];
  assign last_o  = cell_q[LAST];

  // R1: every cell takes the previous value of its neighbour on each edge
  generate
    for (genvar g = 1; g <= LAST; g++) begin : g_adv
      a_r1_cell_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (cell_q[g] == $past(cell_q[g-1])))
        else $error("R1: cell %0d did not take its neighbour's value", g);
    end
  endgenerate

endmodule

// File: rtl/sdl_half_stage.sv
`timescale 1ns/1ps
module sdl_half_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic half_q;
  logic half_d;

  always_comb half_d = d_i;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
    end else begin
      half_q <= half_d;
    end
  end

  assign q_o = half_q;

endmodule

// File: rtl/serial_delay_line.sv
`timescale 1ns/1ps
module serial_delay_line
  import sdl_pkg::*;
#(
  parameter int unsigned CELLS      = DEFAULT_CELLS,
  parameter int unsigned SYNC_FLOPS = DEFAULT_SYNC_FLOPS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic recirc_i,
  input  logic data_i,
  input  logic loop_i,
  output logic q_o,
  output logic qn_o,
  output logic q_half_o,
  output logic clk_fwd_o
);

  logic rst_sync_n;
  logic stage_in;
  logic first_cell;
  logic last_cell;
  logic half_cell;

  sdl_rst_sync #(.FLOPS(SYNC_FLOPS)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  sdl_src_mux u_mux (
    .sel_i  (recirc_i),
    .ext_i  (data_i),
    .loop_i (loop_i),
    .bit_o  (stage_in)
  );

  sdl_shift_chain #(.CELLS(CELLS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .bit_i   (stage_in),
    .first_o (first_cell),
    .last_o  (last_cell)
  );

  sdl_half_stage u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .d_i    (last_cell),
    .q_o    (half_cell)
  );

  assign q_o       = last_cell;
  assign qn_o      = ~last_cell;
  assign q_half_o  = half_cell;
  assign clk_fwd_o = clk_i;

  // R2: external pin lands in the first cell when the selector is low
  a_r2_ext_source: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (recirc_i == 1'b0) |=> (first_cell == $past(data_i)))
    else $error("R2: first cell did not load data_i");

  // R3: loop pin lands in the first cell when the selector is high
  a_r3_loop_source: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (recirc_i == 1'b1) |=> (first_cell == $past(loop_i)))
    else $error("R3: first cell did not load loop_i");

  // R6: by each rising edge the half cell has caught up with the main output
  a_r6_half_caught_up: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    q_half_o == q_o)
    else $error("R6: half cell does not match main output at rising edge");

endmodule

// File: tb/tb_serial_delay_line.sv
`timescale 1ns/1ps
module tb_serial_delay_line;

  localparam int N  = 64;
  localparam int NV = 8;
  // {recirculate after load, word to load, noise on the unselected input}
  localparam logic [128:0] VEC [NV] = '{
    {1'b0, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
    {1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000},
    {1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555},
    {1'b1, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFFE},
    {1'b0, 64'h0123_4567_89AB_CDEF, 64'hF0F0_0F0F_3C3C_C3C3},
    {1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF},
    {1'b1, 64'hDEAD_BEEF_0BAD_F00D, 64'h1357_9BDF_2468_ACE0},
    {1'b0, 64'h00FF_00FF_0F0F_3333, 64'hCAFE_1234_5678_9ABC}
  };

  logic clk_raw, run, hold_lvl, clk;
  logic rst_n, sel, din, loop_drv, loopback;
  logic q, qn, qh, cfwd, loop_w;
  logic [N-1:0] hist;
  int checks, errors, cycles;

  initial clk_raw = 1'b0;
  always #2.5 clk_raw = ~clk_raw;
  assign clk    = run ? clk_raw : hold_lvl;
  assign loop_w = loopback ? q : loop_drv;

  serial_delay_line dut (
    .clk_i(clk), .rst_ni(rst_n), .recirc_i(sel), .data_i(din), .loop_i(loop_w),
    .q_o(q), .qn_o(qn), .q_half_o(qh), .clk_fwd_o(cfwd)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Starts and ends just after a falling edge.
  task automatic step(input logic s, input logic d, input logic l, input logic lb,
                      input string tag);
    logic in_bit, old;
    sel = s; din = d; loop_drv = l; loopback = lb;
    in_bit = s ? (lb ? hist[N-1] : l) : d;
    old = hist[N-1];
    @(posedge clk);
    hist = {hist[N-2:0], in_bit};
    #1;
    chk(tag, q, hist[N-1]);
    chk("R5", qn, ~hist[N-1]);
    chk("R6", qh, old);
    chk("R8", cfwd, clk);
    @(negedge clk);
    #1;
    chk("R6", qh, hist[N-1]);
    chk("R8", cfwd, clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel = 1'b0; din = 1'b0; loop_drv = 1'b0; loopback = 1'b0;
    #1;
    chk("R9", q, 1'b0);
    chk("R9", qn, 1'b1);
    chk("R9", qh, 1'b0);
    repeat (2) @(posedge clk_raw);
    @(negedge clk_raw); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk_raw);
    @(negedge clk_raw); #1;
    chk("R9", q, 1'b0);
    chk("R9", qh, 1'b0);
    hist = '0;
  endtask

  always @(posedge clk_raw) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] pat, noise;
    logic q0, qn0, qh0;
    int seen;
    checks = 0; errors = 0; cycles = 0;
    run = 1'b1; hold_lvl = 1'b0; hist = '0;
    rst_n = 1'b0; sel = 1'b0; din = 1'b0; loop_drv = 1'b0; loopback = 1'b0;
    #1;
    do_reset();

    // Vector table: load each word in data mode, then recirculate or flush it.
    for (int e = 0; e < NV; e++) begin
      pat = VEC[e][127:64];
      noise = VEC[e][63:0];
      for (int k = 0; k < N; k++) step(1'b0, pat[k], noise[k], 1'b0, "R2");
      if (VEC[e][128]) begin
        for (int j = 0; j < 2*N; j++) begin
          step(1'b1, noise[j%N], 1'b0, 1'b1, "R3");
          chk("R4", q, pat[(j+1)%N]);
        end
      end else begin
        for (int j = 0; j < N; j++) step(1'b0, noise[j], pat[j], 1'b0, "R1");
      end
    end

    // R1: single-pulse latency in data mode.
    for (int k = 0; k < N; k++) step(1'b0, 1'b0, 1'b1, 1'b0, "R2");
    seen = -1;
    for (int k = 0; k < N + 4; k++) begin
      step(1'b0, (k == 0), 1'b0, 1'b0, "R1");
      if (q === 1'b1 && seen < 0) seen = k + 1;
    end
    checks++;
    if (seen != N) begin
      errors++;
      $display("FAIL R1: actual latency %0d expected %0d", seen, N);
    end

    // R3 without loopback: the loop pin itself is the source.
    for (int k = 0; k < N; k++) step(1'b1, k[0], k[1], 1'b0, "R3");

    // R7: clock frozen low.
    for (int k = 0; k < 5; k++) step(1'b0, k[0], 1'b0, 1'b0, "R2");
    q0 = q; qn0 = qn; qh0 = qh;
    hold_lvl = 1'b0; run = 1'b0;
    for (int k = 0; k < 12; k++) begin
      sel = k[0]; din = k[1]; loop_drv = ~k[0];
      #5;
    end
    chk("R7", q, q0); chk("R7", qn, qn0); chk("R7", qh, qh0);
    chk("R8", cfwd, 1'b0);
    @(negedge clk_raw); run = 1'b1; #1;

    // R7: clock frozen high, straight after a rising edge.
    sel = 1'b0; din = ~hist[N-1]; loop_drv = 1'b0; loopback = 1'b0;
    qh0 = hist[N-1];
    @(posedge clk);
    hist = {hist[N-2:0], din};
    #1;
    hold_lvl = 1'b1; run = 1'b0;
    q0 = q;
    for (int k = 0; k < 12; k++) begin
      sel = k[1]; din = k[0]; loop_drv = k[2];
      #5;
    end
    chk("R7", q, q0); chk("R7", q, hist[N-1]); chk("R7", qh, qh0);
    chk("R8", cfwd, 1'b1);
    @(posedge clk_raw); run = 1'b1;
    @(negedge clk); #1;
    chk("R6", qh, hist[N-1]);

    // R9: reset in the middle of activity.
    for (int k = 0; k < N; k++) step(1'b0, 1'b1, 1'b0, 1'b0, "R2");
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b0, 1'b1, 1'b1, 1'b0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule